// File: doc/BRIEF.md
# Adaptive Dual-Protocol Register Port

This block is the host-facing register port of a telephony signalling device. It lets a microcontroller reach a small register file without any pin strap or configuration register that selects the bus convention. Each time the combined active-low chip select falls, the port samples the shared strobe line. The level found there selects one of two conventions for the whole access. With the line low, the port uses data-strobe timing with a separate read/write direction line. With the line high, it uses separate active-low read and write strobes.

The same port serves hosts with a separate address line and hosts that carry the register address on the data bus. A static bus-type input decides where the address is taken at the chip-select falling edge. Write data is committed when the write strobe ends. During a read, the port drives the data bus only while the read strobe is active. A status register collects sticky event flags from the rest of the device. The flags keep updating while the host bus sits idle, and a status read clears the flags that read returned.

All bus inputs are asynchronous to the device clock. They pass through two-flop synchronizers, and every edge is detected on the synchronized copies.

Top module: `host_port_adapt`

## Requirements
- R1: After reset, data_oe_o, irq_o, tx_data_o and ctrl_o are all 0.
- R2: When ds_rd_i is high at the cs_ni falling edge, the access uses separate strobes. ds_rd_i low is the read strobe, and rw_wr_i low is the write strobe.
- R3: When ds_rd_i is low at the cs_ni falling edge, the access uses data-strobe timing. ds_rd_i high is the strobe, with rw_wr_i=1 for a read and rw_wr_i=0 for a write.
- R4: The convention chosen at the chip-select falling edge holds until cs_ni rises, whatever ds_rd_i does later in that access. Consecutive accesses may use different conventions.
- R5: With mux_bus_i=0, the register address is reg_sel_i as sampled at the cs_ni falling edge. Later changes of reg_sel_i in that access have no effect.
- R6: With mux_bus_i=1, the register address is data_i[0] as sampled at the cs_ni falling edge, and reg_sel_i is ignored.
- R7: Address map. A write to address 0 loads tx_data_o, and a write to address 1 loads ctrl_o. A read of address 0 returns rx_data_i. A read of address 1 returns the status byte, whose bits [3:0] are the flags and whose upper bits are 0.
- R8: A write commits the last data_i value seen while the write strobe was active. The commit happens when the strobe ends.
- R9: data_oe_o is high only while a read strobe is active inside an access with cs_ni low, and data_o is 0 whenever data_oe_o is low. Strobe activity while cs_ni is high changes no register.
- R10: Each bit of evt_i that is high on a clock edge sets the matching sticky flag. irq_o is the OR of the flags. Flags persist for any idle time on the host bus.
- R11: When a read strobe on address 1 ends, the flags returned by that read are cleared. A read of address 0 clears nothing, and an event arriving in the clearing cycle survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Combined chip select, active low |
| ds_rd_i | input | 1 | Shared data strobe / read strobe |
| rw_wr_i | input | 1 | Read/write direction or active-low write strobe |
| reg_sel_i | input | 1 | Register select for buses with a separate address |
| mux_bus_i | input | 1 | 1 = address is carried on the data bus |
| data_i | input | DW | Host data bus, inbound |
| data_o | output | DW | Host data bus, outbound |
| data_oe_o | output | 1 | Drive enable for data_o |
| rx_data_i | input | DW | Received-data value presented for reads |
| evt_i | input | SW | Event pulses that set the status flags |
| tx_data_o | output | DW | Transmit data register |
| ctrl_o | output | DW | Control register |
| irq_o | output | 1 | OR of the sticky flags |

## Verification
The assertions assume that each access keeps cs_ni low long enough for its strobe to be seen through the synchronizers. They also assume that cs_ni stays high for several clocks between accesses, and that read and write strobes are never active together. The bench meets these assumptions by holding every bus level for at least three clocks. It places the mode level and the address two clocks ahead of the chip-select falling edge and releases chip select only after the strobe has ended. Event pulses are synchronous to the device clock and may fall anywhere, including the cycle in which a status read clears the flags.

// File: rtl/host_port_pkg.sv
package host_port_pkg;
  typedef enum logic {
    BUS_STROBE_DIR = 1'b0,
    BUS_SPLIT_RW   = 1'b1
  } bus_kind_e;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_AUX  = 1'b1;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        stab_q <= meta_q;
      end
    end
    assign q_o[i] = stab_q;
  end
endmodule

// File: rtl/hp_access_ctl.sv
module hp_access_ctl
  import host_port_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cs_n_s_i,
  input  logic      dsrd_s_i,
  input  logic      rwwr_s_i,
  input  logic      sel_s_i,
  input  logic      mux_s_i,
  input  logic      d0_s_i,
  output logic      active_o,
  output bus_kind_e kind_o,
  output logic      addr_o,
  output logic      rd_act_o,
  output logic      wr_act_o
);
  logic      cs_n_q, active_q, addr_q;
  bus_kind_e kind_q;
  logic      cs_fall, in_acc;

  assign cs_fall = cs_n_q & ~cs_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q   <= 1'b1;
      active_q <= 1'b0;
      kind_q   <= BUS_STROBE_DIR;
      addr_q   <= ADDR_DATA;
    end else begin
      cs_n_q <= cs_n_s_i;
      if (cs_fall) begin
        active_q <= 1'b1;
        kind_q   <= dsrd_s_i ? BUS_SPLIT_RW : BUS_STROBE_DIR;
        addr_q   <= mux_s_i ? d0_s_i : sel_s_i;
      end else if (cs_n_s_i) begin
        active_q <= 1'b0;
      end
    end
  end

  // strobe decode uses the convention latched at select time
  assign in_acc = active_q & ~cs_n_s_i;
  always_comb begin
    if (kind_q == BUS_SPLIT_RW) begin
      rd_act_o = in_acc & ~dsrd_s_i;
      wr_act_o = in_acc & ~rwwr_s_i;
    end else begin
      rd_act_o = in_acc & dsrd_s_i & rwwr_s_i;
      wr_act_o = in_acc & dsrd_s_i & ~rwwr_s_i;
    end
  end

  assign active_o = active_q;
  assign kind_o   = kind_q;
  assign addr_o   = addr_q;
endmodule

// File: rtl/hp_regs.sv
module hp_regs
  import host_port_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_act_i,
  input  logic          wr_act_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic [SW-1:0] evt_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] tx_data_o,
  output logic [DW-1:0] ctrl_o,
  output logic          irq_o
);
  localparam int unsigned PAD = DW - SW;

  logic          wr_q, rd_q, wr_end, rd_end;
  logic [DW-1:0] wbuf_q, tx_q, ctrl_q;
  logic [SW-1:0] flags_q, snap_q, clr_mask;

  assign wr_end   = wr_q & ~wr_act_i;
  assign rd_end   = rd_q & ~rd_act_i;
  assign clr_mask = (rd_end && addr_i == ADDR_AUX) ? snap_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      wbuf_q  <= '0;
      tx_q    <= '0;
      ctrl_q  <= '0;
      flags_q <= '0;
      snap_q  <= '0;
    end else begin
      wr_q <= wr_act_i;
      rd_q <= rd_act_i;
      if (wr_act_i) wbuf_q <= wdata_i;
      if (wr_end) begin
        if (addr_i == ADDR_AUX) ctrl_q <= wbuf_q;
        else                    tx_q   <= wbuf_q;
      end
      if (rd_act_i) snap_q <= flags_q;
      // new events win over the clear
      flags_q <= (flags_q & ~clr_mask) | evt_i;
    end
  end

  assign rdata_o   = (addr_i == ADDR_AUX) ? {{PAD{1'b0}}, flags_q} : rx_data_i;
  assign tx_data_o = tx_q;
  assign ctrl_o    = ctrl_q;
  assign irq_o     = |flags_q;
endmodule

// File: rtl/host_port_adapt.sv
module host_port_adapt
  import host_port_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          ds_rd_i,
  input  logic          rw_wr_i,
  input  logic          reg_sel_i,
  input  logic          mux_bus_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic [DW-1:0] rx_data_i,
  input  logic [SW-1:0] evt_i,
  output logic [DW-1:0] tx_data_o,
  output logic [DW-1:0] ctrl_o,
  output logic          irq_o
);
  localparam int unsigned NIN = DW + 5;
  localparam int unsigned B_CS = DW;
  localparam int unsigned B_DS = DW + 1;
  localparam int unsigned B_RW = DW + 2;
  localparam int unsigned B_RS = DW + 3;
  localparam int unsigned B_MX = DW + 4;
  localparam logic [NIN-1:0] IN_IDLE = NIN'((1 << B_CS) | (1 << B_RW));

  logic [NIN-1:0] raw_in, syn;
  logic           cs_s, active_q, addr_q, rd_act, wr_act;
  bus_kind_e      kind_q;
  logic [DW-1:0]  rdata;

  assign raw_in = {mux_bus_i, reg_sel_i, rw_wr_i, ds_rd_i, cs_ni, data_i};

  hp_sync #(.W(NIN), .RST_VAL(IN_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn)
  );

  assign cs_s = syn[B_CS];

  hp_access_ctl u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_s_i(cs_s),
    .dsrd_s_i(syn[B_DS]),
    .rwwr_s_i(syn[B_RW]),
    .sel_s_i (syn[B_RS]),
    .mux_s_i (syn[B_MX]),
    .d0_s_i  (syn[0]),
    .active_o(active_q),
    .kind_o  (kind_q),
    .addr_o  (addr_q),
    .rd_act_o(rd_act),
    .wr_act_o(wr_act)
  );

  hp_regs #(.DW(DW), .SW(SW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_act_i (rd_act),
    .wr_act_i (wr_act),
    .addr_i   (addr_q),
    .wdata_i  (syn[DW-1:0]),
    .rx_data_i(rx_data_i),
    .evt_i    (evt_i),
    .rdata_o  (rdata),
    .tx_data_o(tx_data_o),
    .ctrl_o   (ctrl_o),
    .irq_o    (irq_o)
  );

  assign data_oe_o = rd_act;
  assign data_o    = rd_act ? rdata : '0;
endmodule

// File: rtl/host_port_adapt_chk.sv
module host_port_adapt_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          data_oe_o,
  input logic [DW-1:0] data_o,
  input logic          cs_s,
  input logic          active_q,
  input logic          kind_q,
  input logic          addr_q,
  input logic          wr_act,
  input logic [DW-1:0] tx_data_o,
  input logic [SW-1:0] evt_i,
  input logic          irq_o
);
  AST_OE_IN_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (active_q && !cs_s)); // R9
  AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0)); // R9
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q)) |-> $stable(kind_q)); // R4
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q)) |-> $stable(addr_q)); // R5
  AST_TX_AT_STROBE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_data_o) |-> (!$past(wr_act) && $past(wr_act, 2))); // R8
  AST_EVT_SETS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> irq_o); // R10
endmodule

bind host_port_adapt host_port_adapt_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .data_oe_o(data_oe_o),
  .data_o   (data_o),
  .cs_s     (cs_s),
  .active_q (active_q),
  .kind_q   (kind_q),
  .addr_q   (addr_q),
  .wr_act   (wr_act),
  .tx_data_o(tx_data_o),
  .evt_i    (evt_i),
  .irq_o    (irq_o)
);

// File: tb/host_port_adapt_test.sv
module host_port_adapt_test;
  logic       clk = 0, rst_n = 0;
  logic       cs_n = 1, ds_rd = 0, rw_wr = 1, rs = 0, mux = 0;
  logic [7:0] din = 0, rx = 0;
  logic [3:0] evt = 0;
  logic [7:0] dout, tx, ctrl;
  logic       oe, irq;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  host_port_adapt uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ds_rd_i(ds_rd), .rw_wr_i(rw_wr),
    .reg_sel_i(rs), .mux_bus_i(mux), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .rx_data_i(rx), .evt_i(evt), .tx_data_o(tx), .ctrl_o(ctrl), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model: index 0 newest sample, 1 = synchronized view, 2 = one older
  logic       hcs[3], hds[3], hrw[3], hrs[3], hmx[3];
  logic [7:0] hd[3];
  logic       m_act, m_split, m_addr, m_wr_p, m_rd_p;
  logic [7:0] m_wbuf, m_tx, m_ctrl;
  logic [3:0] m_flags, m_snap;

  function automatic logic m_rd();
    if (!m_act || hcs[1]) return 1'b0;
    return m_split ? !hds[1] : (hds[1] && hrw[1]);
  endfunction
  function automatic logic m_wr();
    if (!m_act || hcs[1]) return 1'b0;
    return m_split ? !hrw[1] : (hds[1] && !hrw[1]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic rd, wr, fall;
    logic [3:0] old_flags;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        hcs[i] = 1; hds[i] = 0; hrw[i] = 1; hrs[i] = 0; hmx[i] = 0; hd[i] = 0;
      end
      m_act = 0; m_split = 0; m_addr = 0; m_wr_p = 0; m_rd_p = 0;
      m_wbuf = 0; m_tx = 0; m_ctrl = 0; m_flags = 0; m_snap = 0;
    end else begin
      rd = m_rd(); wr = m_wr(); fall = hcs[2] && !hcs[1];
      old_flags = m_flags;
      if (m_wr_p && !wr) begin
        if (m_addr) m_ctrl = m_wbuf; else m_tx = m_wbuf;
      end
      if (wr) m_wbuf = hd[1];
      if (m_rd_p && !rd && m_addr) m_flags = m_flags & ~m_snap;
      m_flags = m_flags | evt;
      if (rd) m_snap = old_flags;
      if (fall) begin
        m_act = 1; m_split = hds[1]; m_addr = hmx[1] ? hd[1][0] : hrs[1];
      end else if (hcs[1]) m_act = 0;
      m_wr_p = wr; m_rd_p = rd;
      for (int i = 2; i > 0; i--) begin
        hcs[i] = hcs[i-1]; hds[i] = hds[i-1]; hrw[i] = hrw[i-1];
        hrs[i] = hrs[i-1]; hmx[i] = hmx[i-1]; hd[i] = hd[i-1];
      end
      hcs[0] = cs_n; hds[0] = ds_rd; hrw[0] = rw_wr; hrs[0] = rs; hmx[0] = mux; hd[0] = din;
    end
  end

  // per-clock comparison against the model
  always @(posedge clk) begin
    if (rst_n && !done) begin
      logic eoe;
      logic [7:0] edat;
      #2;
      eoe  = m_rd();
      edat = eoe ? (m_addr ? {4'h0, m_flags} : rx) : 8'h00;
      chk(oe === eoe, "R9 data_oe_o", oe, eoe);
      chk(dout === edat, "R7 data_o", dout, edat);
      chk(tx === m_tx, "R8 tx_data_o", tx, m_tx);
      chk(ctrl === m_ctrl, "R8 ctrl_o", ctrl, m_ctrl);
      chk(irq === (|m_flags), "R10/R11 irq_o", irq, |m_flags);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one host access; split = 1 selects separate strobes
  task automatic access(input bit split, input bit is_wr, input bit a,
                        input logic [7:0] wv, input bit flip_sel, output logic [7:0] rv,
                        output bit saw_oe);
    @(negedge clk);
    ds_rd = split;
    rw_wr = split ? 1'b1 : !is_wr;
    rs    = mux ? !a : a;
    din   = mux ? {7'h0, a} : {7'h0, !a};
    wait_n(2);
    cs_n = 0;
    wait_n(4);
    if (flip_sel) begin rs = !rs; din[0] = !din[0]; end
    if (is_wr) begin
      din = wv;
      if (split) rw_wr = 0; else ds_rd = 1;
      wait_n(4);
      if (split) rw_wr = 1; else ds_rd = 0;
      din = ~wv;
      rv = 0; saw_oe = 0;
    end else begin
      if (split) ds_rd = 0; else ds_rd = 1;
      wait_n(4);
      rv = dout; saw_oe = oe;
      if (split) ds_rd = 1; else ds_rd = 0;
    end
    wait_n(3);
    cs_n = 1;
    wait_n(4);
  endtask

  initial begin
    logic [7:0] rv;
    bit so;
    logic [7:0] save;
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    chk(oe === 0 && irq === 0, "R1 oe/irq", {oe, irq}, 0);
    chk(tx === 0 && ctrl === 0, "R1 regs", {tx, ctrl}, 0);

    access(1, 1, 0, 8'h3C, 0, rv, so);
    chk(tx === 8'h3C, "R2 split write tx", tx, 8'h3C);
    access(0, 1, 1, 8'hA5, 0, rv, so);
    chk(ctrl === 8'hA5, "R3 strobe-dir write ctrl", ctrl, 8'hA5);
    chk(tx === 8'h3C, "R7 tx untouched", tx, 8'h3C);
    rx = 8'h96;
    access(1, 0, 0, 0, 0, rv, so);
    chk(so && rv === 8'h96, "R2 split read rx", rv, 8'h96);
    rx = 8'h4B;
    access(0, 0, 0, 0, 0, rv, so);
    chk(so && rv === 8'h4B, "R4 strobe-dir read after split access", rv, 8'h4B);
    access(1, 1, 0, 8'h77, 1, rv, so);
    chk(tx === 8'h77 && ctrl === 8'hA5, "R5 late reg_sel change ignored", {tx, ctrl}, 16'h77A5);

    mux = 1;
    wait_n(4);
    access(0, 1, 1, 8'h11, 0, rv, so);
    chk(ctrl === 8'h11 && tx === 8'h77, "R6 address from data bit 0", {tx, ctrl}, 16'h7711);
    access(1, 0, 1, 0, 0, rv, so);
    chk(so && rv === 8'h00, "R6 mux read status", rv, 0);
    mux = 0;
    wait_n(4);

    // strobes with chip select high
    save = tx;
    rw_wr = 0; din = 8'hEE; wait_n(5); rw_wr = 1; wait_n(3);
    ds_rd = 0; wait_n(3); ds_rd = 1; wait_n(5); ds_rd = 0; wait_n(5);
    chk(tx === save && ctrl === 8'h11, "R9 no write without select", tx, save);
    chk(oe === 0, "R9 no drive without select", oe, 0);

    evt = 4'b0101; @(negedge clk); evt = 0;
    wait_n(200);
    chk(irq === 1, "R10 flags persist when idle", irq, 1);
    access(1, 0, 0, 0, 0, rv, so);
    chk(irq === 1, "R11 data read keeps flags", irq, 1);
    access(0, 0, 1, 0, 0, rv, so);
    chk(rv === 8'h05, "R7 status byte", rv, 8'h05);
    chk(irq === 0, "R11 status read clears", irq, 0);

    // events landing around the end of status reads
    for (int k = 0; k < 10; k++) begin
      fork
        access(k[0], 0, 1, 0, 0, rv, so);
        begin wait_n(10 + k); evt = 4'(k + 1); @(negedge clk); evt = 0; end
      join
    end
    evt = 4'b1000; @(negedge clk); evt = 0;
    wait_n(3);
    access(1, 0, 1, 0, 0, rv, so);
    chk(rv[3] === 1'b1, "R11 late event visible", rv, 8'h08);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule